// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block computes the Montgomery product `x * y * 2^-W mod m` for a modulus `m` that is odd and narrower than the active width `W`. The three operands arrive on parallel buses and are captured on a one-cycle start pulse. The multiplier consumes one bit of `x` per step. Each step is split into two clock cycles. In the first cycle the reduction bit is chosen from the accumulator LSB. In the second cycle the multiple of `y`, the multiple of `m` and the ripple carries are added across a chain of equal-width slices, and the sum is shifted right by one bit. After the last step, one conditional subtraction brings the value into `[0, m-1]`. The result is then held on the output and `ready` rises.

The slice chain can be split at a fixed boundary into a lower segment and an upper segment, so a narrow operand occupies only part of the chain. With the default parameters (4-bit slices, six slices, two of them in the lower segment) the chain handles 8, 16 or 24 bits. The same structure scales to 512/1024/1536 bits by changing the slice width and the slice count.

To move a value `g` into Montgomery form, multiply it by `R^2 mod m`, where `R = 2^W`. To bring a value back out of Montgomery form, multiply it by the constant 1.

Top module: `montmul_serial`

## Requirements
- R1: When `x < m`, `y < m` and `m` is odd, the result equals `x*y*2^-W mod m`, where `W` is the active width.
- R2: `part_sel` chooses the active width. `2'b01` selects the lower segment (`LOWER_STAGES*STAGE_W` bits, 8 by default). `2'b10` selects the upper segment (the remaining slices, 16 bits by default). `2'b11` selects the whole chain (24 bits by default). A start pulse with `part_sel = 2'b00` is ignored and leaves `ready` and `result` unchanged. Operands and result always sit in the least significant bits of their buses.
- R3: Let E0 be the clock edge that samples an accepted start. `ready` rises exactly `NUM_STAGES + 2*(W-1)` edges after E0 and is low at every edge before that.
- R4: A start pulse that arrives while a multiplication is in progress is ignored. The running operation keeps its operands, its result and its timing.
- R5: An accepted start clears `ready` at E0. After that, `ready` stays high and `result` stays stable until the next accepted start.
- R6: Every result is fully reduced, that is, strictly less than `m`.
- R7: Input bits at and above the active width are ignored, and the result bits at and above the active width are zero.
- R8: Reset is synchronous and active high. It clears `ready` and abandons any multiplication in progress, so that `ready` does not rise afterwards until a new start is accepted.
- R9: Multiplying `g < m` by `R^2 mod m` and then multiplying that product by 1 returns `g`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| part_sel | input | 2 | Segment select: 01 lower, 10 upper, 11 full, 00 none |
| x_in | input | STAGE_W*NUM_STAGES | Multiplier operand, consumed bit-serially |
| y_in | input | STAGE_W*NUM_STAGES | Multiplicand operand |
| m_in | input | STAGE_W*NUM_STAGES | Odd modulus |
| result | output | STAGE_W*NUM_STAGES | Reduced Montgomery product |
| ready | output | 1 | High while `result` is valid |

## Verification
The result and `ready` are due at the edge that lies `NUM_STAGES + 2*(W-1)` edges after the edge that samples start. That is 20, 36 and 52 edges for the lower, upper and full segments. The bench drives start on a falling edge and counts rising edges from E0. It checks that `ready` is still low on the falling edge after edge L-1, then checks `ready` and `result` on the falling edge after edge L. Ignored starts, the hold after completion and the reset abort are all checked a whole number of cycles after the stimulus, before any further input is applied. Expected values come from a modular inverse of `2^W`, computed in the bench as `((m+1)/2)^W mod m`.

// File: rtl/mm_pkg.sv
`timescale 1ns/1ps
package mm_pkg;

    typedef enum logic [1:0] {
        SEG_NONE = 2'b00,
        SEG_LOW  = 2'b01,
        SEG_HIGH = 2'b10,
        SEG_ALL  = 2'b11
    } seg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QBIT,
        ST_ADD,
        ST_FIN,
        ST_DRAIN
    } mm_state_e;

endpackage

// File: rtl/mm_stage.sv
`timescale 1ns/1ps
// One accumulator slice of the serial Montgomery chain.
module mm_stage #(
    parameter int STAGE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               en,
    input  logic [STAGE_W-1:0] y_sl,
    input  logic [STAGE_W-1:0] m_sl,
    input  logic               xi,
    input  logic               q,
    input  logic [1:0]         cin,
    input  logic               sh_in,
    output logic [STAGE_W-1:0] acc_o,
    output logic [1:0]         cout,
    output logic               sum_lsb
);
    localparam int SUM_W = STAGE_W + 2;

    logic [STAGE_W-1:0] acc_d, acc_q;
    logic [SUM_W-1:0]   sum;
    logic [STAGE_W:0]   shifted;

    always_comb begin
        sum = SUM_W'(acc_q)
            + (xi ? SUM_W'(y_sl) : '0)
            + (q  ? SUM_W'(m_sl) : '0)
            + SUM_W'(cin);
        shifted = {sh_in, sum[STAGE_W-1:0]};
        acc_d   = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = shifted[STAGE_W:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o   = acc_q;
    assign cout    = sum[SUM_W-1:STAGE_W];
    assign sum_lsb = sum[0];
endmodule

// File: rtl/mm_chain.sv
`timescale 1ns/1ps
// Partitionable slice chain: reduction-bit register, slices, top extension.
module mm_chain
    import mm_pkg::*;
#(
    parameter int STAGE_W      = 4,
    parameter int NUM_STAGES   = 6,
    parameter int LOWER_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          q_phase,
    input  logic                          add_phase,
    input  logic [1:0]                    seg,
    input  logic                          xi,
    input  logic [STAGE_W*NUM_STAGES-1:0] y_al,
    input  logic [STAGE_W*NUM_STAGES-1:0] m_al,
    output logic [STAGE_W*NUM_STAGES-1:0] acc,
    output logic [1:0]                    ext
);
    localparam int W_MAX   = STAGE_W * NUM_STAGES;
    localparam int LOWER_W = STAGE_W * LOWER_STAGES;

    logic                         q_d, q_q;
    logic [1:0]                   ext_d, ext_q;
    logic [NUM_STAGES-1:0][1:0]   cout;
    logic [NUM_STAGES-1:0]        lsb_v;
    logic [1:0]                   top_cout;
    logic [2:0]                   top_sum;
    logic                         base_acc, base_y;

    // Slice index of the segment's lowest and highest slice.
    always_comb begin
        top_cout = (seg == SEG_LOW) ? cout[LOWER_STAGES-1] : cout[NUM_STAGES-1];
        top_sum  = 3'(ext_q) + 3'(top_cout);
        base_acc = (seg == SEG_HIGH) ? acc[LOWER_W]  : acc[0];
        base_y   = (seg == SEG_HIGH) ? y_al[LOWER_W] : y_al[0];
    end

    always_comb begin
        q_d   = q_q;
        ext_d = ext_q;
        if (clr) begin
            q_d   = 1'b0;
            ext_d = '0;
        end else if (q_phase) begin
            q_d = base_acc ^ (xi & base_y);
        end else if (add_phase) begin
            ext_d = top_sum[2:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q   <= 1'b0;
            ext_q <= '0;
        end else begin
            q_q   <= q_d;
            ext_q <= ext_d;
        end
    end

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_slice
        logic       active, is_base, is_top, sh_in;
        logic [1:0] cin;

        always_comb begin
            case (seg)
                SEG_LOW:  active = (k < LOWER_STAGES);
                SEG_HIGH: active = (k >= LOWER_STAGES);
                SEG_ALL:  active = 1'b1;
                default:  active = 1'b0;
            endcase
            is_base = (seg == SEG_HIGH) ? (k == LOWER_STAGES) : (k == 0);
            is_top  = (seg == SEG_LOW) ? (k == LOWER_STAGES - 1) : (k == NUM_STAGES - 1);
        end

        if (k == 0) begin : g_first
            assign cin = 2'b00;
        end else begin : g_rest
            assign cin = is_base ? 2'b00 : cout[k-1];
        end

        if (k == NUM_STAGES - 1) begin : g_last
            assign sh_in = top_sum[0];
        end else begin : g_mid
            assign sh_in = is_top ? top_sum[0] : lsb_v[k+1];
        end

        mm_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .en      (add_phase & active),
            .y_sl    (y_al[k*STAGE_W +: STAGE_W]),
            .m_sl    (m_al[k*STAGE_W +: STAGE_W]),
            .xi      (xi),
            .q       (q_q),
            .cin     (cin),
            .sh_in   (sh_in),
            .acc_o   (acc[k*STAGE_W +: STAGE_W]),
            .cout    (cout[k]),
            .sum_lsb (lsb_v[k])
        );
    end

    assign ext = ext_q;

    logic unused_lsb;
    assign unused_lsb = lsb_v[0];
endmodule

// File: rtl/mm_ctrl.sv
`timescale 1ns/1ps
// Sequencer: two cycles per operand bit, one final cycle, drain to fixed latency.
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int STAGE_W      = 4,
    parameter int NUM_STAGES   = 6,
    parameter int LOWER_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] part_sel,
    output logic       load,
    output logic [1:0] seg,
    output logic       q_phase,
    output logic       add_phase,
    output logic       fin_phase,
    output logic       ready
);
    localparam int W_MAX   = STAGE_W * NUM_STAGES;
    localparam int LOWER_W = STAGE_W * LOWER_STAGES;
    localparam int UPPER_W = W_MAX - LOWER_W;
    localparam int BIT_W   = $clog2(W_MAX + 1);
    localparam int CNT_W   = $clog2(NUM_STAGES + 2 * W_MAX + 1);

    function automatic int seg_width(logic [1:0] s);
        case (s)
            SEG_LOW:  return LOWER_W;
            SEG_HIGH: return UPPER_W;
            default:  return W_MAX;
        endcase
    endfunction

    typedef struct packed {
        mm_state_e        state;
        logic [1:0]       seg;
        logic [BIT_W-1:0] bitcnt;
        logic [CNT_W-1:0] cyc;
        logic             ready;
    } ctrl_t;

    ctrl_t            s_d, s_q;
    logic             accept;
    logic [CNT_W-1:0] lat;
    logic [BIT_W-1:0] last_bit;

    always_comb begin
        accept   = start && (s_q.state == ST_IDLE) && (part_sel != SEG_NONE);
        lat      = CNT_W'(NUM_STAGES + 2 * (seg_width(s_q.seg) - 1));
        last_bit = BIT_W'(seg_width(s_q.seg) - 1);
        s_d      = s_q;
        case (s_q.state)
            ST_IDLE: begin
                if (accept) begin
                    s_d.state  = ST_QBIT;
                    s_d.seg    = part_sel;
                    s_d.bitcnt = '0;
                    s_d.cyc    = CNT_W'(1);
                    s_d.ready  = 1'b0;
                end
            end
            ST_QBIT: begin
                s_d.state = ST_ADD;
                s_d.cyc   = s_q.cyc + 1'b1;
            end
            ST_ADD: begin
                s_d.cyc = s_q.cyc + 1'b1;
                if (s_q.bitcnt == last_bit) begin
                    s_d.state = ST_FIN;
                end else begin
                    s_d.bitcnt = s_q.bitcnt + 1'b1;
                    s_d.state  = ST_QBIT;
                end
            end
            ST_FIN, ST_DRAIN: begin
                if (s_q.cyc == lat) begin
                    s_d.state = ST_IDLE;
                    s_d.ready = 1'b1;
                end else begin
                    s_d.state = ST_DRAIN;
                    s_d.cyc   = s_q.cyc + 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{state: ST_IDLE, seg: 2'b00, bitcnt: '0, cyc: '0, ready: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign load      = accept;
    assign seg       = s_q.seg;
    assign q_phase   = (s_q.state == ST_QBIT);
    assign add_phase = (s_q.state == ST_ADD);
    assign fin_phase = (s_q.state == ST_FIN);
    assign ready     = s_q.ready;
endmodule

// File: rtl/montmul_serial.sv
`timescale 1ns/1ps
module montmul_serial
    import mm_pkg::*;
#(
    parameter int STAGE_W      = 4,
    parameter int NUM_STAGES   = 6,
    parameter int LOWER_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [1:0]                    part_sel,
    input  logic [STAGE_W*NUM_STAGES-1:0] x_in,
    input  logic [STAGE_W*NUM_STAGES-1:0] y_in,
    input  logic [STAGE_W*NUM_STAGES-1:0] m_in,
    output logic [STAGE_W*NUM_STAGES-1:0] result,
    output logic                          ready
);
    localparam int W_MAX   = STAGE_W * NUM_STAGES;
    localparam int LOWER_W = STAGE_W * LOWER_STAGES;
    localparam int UPPER_W = W_MAX - LOWER_W;
    localparam int EXT_W   = W_MAX + 2;

    typedef struct packed {
        logic [W_MAX-1:0] x_sh;
        logic [W_MAX-1:0] y_al;
        logic [W_MAX-1:0] m_al;
        logic [W_MAX-1:0] m_eff;
        logic [W_MAX-1:0] res;
    } data_t;

    data_t            r_d, r_q;
    logic             load, q_phase, add_phase, fin_phase;
    logic [1:0]       seg;
    logic [W_MAX-1:0] acc;
    logic [1:0]       ext;

    function automatic logic [W_MAX-1:0] width_mask(logic [1:0] s);
        case (s)
            SEG_LOW:  return W_MAX'((64'd1 << LOWER_W) - 64'd1);
            SEG_HIGH: return W_MAX'((64'd1 << UPPER_W) - 64'd1);
            default:  return '1;
        endcase
    endfunction

    mm_ctrl #(
        .STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES), .LOWER_STAGES(LOWER_STAGES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .part_sel  (part_sel),
        .load      (load),
        .seg       (seg),
        .q_phase   (q_phase),
        .add_phase (add_phase),
        .fin_phase (fin_phase),
        .ready     (ready)
    );

    mm_chain #(
        .STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES), .LOWER_STAGES(LOWER_STAGES)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .clr       (load),
        .q_phase   (q_phase),
        .add_phase (add_phase),
        .seg       (seg),
        .xi        (r_q.x_sh[0]),
        .y_al      (r_q.y_al),
        .m_al      (r_q.m_al),
        .acc       (acc),
        .ext       (ext)
    );

    logic [W_MAX-1:0] mask_in;
    logic [EXT_W-1:0] full_val;
    logic [EXT_W-1:0] mod_ext;

    always_comb begin
        mask_in = width_mask(part_sel);
        case (seg)
            SEG_LOW:  full_val = EXT_W'(acc[LOWER_W-1:0]) | (EXT_W'(ext) << LOWER_W);
            SEG_HIGH: full_val = EXT_W'(acc >> LOWER_W)   | (EXT_W'(ext) << UPPER_W);
            default:  full_val = {ext, acc};
        endcase
        mod_ext = EXT_W'(r_q.m_eff);

        r_d = r_q;
        if (load) begin
            r_d.x_sh  = x_in & mask_in;
            r_d.m_eff = m_in & mask_in;
            if (part_sel == SEG_HIGH) begin
                r_d.y_al = (y_in & mask_in) << LOWER_W;
                r_d.m_al = (m_in & mask_in) << LOWER_W;
            end else begin
                r_d.y_al = y_in & mask_in;
                r_d.m_al = m_in & mask_in;
            end
        end else if (add_phase) begin
            r_d.x_sh = r_q.x_sh >> 1;
        end else if (fin_phase) begin
            r_d.res = (full_val >= mod_ext) ? W_MAX'(full_val - mod_ext) : W_MAX'(full_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign result = r_q.res;
endmodule

// File: rtl/mm_check.sv
`timescale 1ns/1ps
module mm_check #(
    parameter int STAGE_W      = 4,
    parameter int NUM_STAGES   = 6,
    parameter int LOWER_STAGES = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          start,
    input logic [1:0]                    part_sel,
    input logic [STAGE_W*NUM_STAGES-1:0] m_in,
    input logic [STAGE_W*NUM_STAGES-1:0] result,
    input logic                          ready
);
    localparam int W_MAX   = STAGE_W * NUM_STAGES;
    localparam int LOWER_W = STAGE_W * LOWER_STAGES;
    localparam int CNT_W   = $clog2(NUM_STAGES + 2 * W_MAX + 1);

    function automatic int wsel(logic [1:0] s);
        case (s)
            2'b01:   return LOWER_W;
            2'b10:   return W_MAX - LOWER_W;
            default: return W_MAX;
        endcase
    endfunction

    logic             busy_c;
    logic [CNT_W-1:0] cnt_c, lat_c;
    logic [W_MAX-1:0] m_c;
    logic [1:0]       seg_c;
    logic             acc_c;

    assign acc_c = start && !busy_c && (part_sel != 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c <= 1'b0;
            cnt_c  <= '0;
            lat_c  <= '0;
            m_c    <= '0;
            seg_c  <= 2'b11;
        end else if (acc_c) begin
            busy_c <= 1'b1;
            cnt_c  <= CNT_W'(1);
            lat_c  <= CNT_W'(NUM_STAGES + 2 * (wsel(part_sel) - 1));
            m_c    <= m_in & W_MAX'((65'd1 << wsel(part_sel)) - 65'd1);
            seg_c  <= part_sel;
        end else if (busy_c) begin
            if (cnt_c == lat_c) begin
                busy_c <= 1'b0;
            end else begin
                cnt_c <= cnt_c + 1'b1;
            end
        end
    end

    assert_reset_clears_R8: assert property (@(posedge clk) rst |=> !ready);

    assert_no_early_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_c && cnt_c != lat_c) |=> !ready);

    assert_ready_on_time_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_c && cnt_c == lat_c) |=> ready);

    assert_busy_ignores_start_R4: assert property (@(posedge clk) disable iff (rst)
        busy_c |-> !ready);

    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (rst)
        acc_c |=> !ready);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && !(start && part_sel != 2'b00)) |=> (ready && $stable(result)));

    assert_reduced_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (result < m_c));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        ready |-> ((65'(result) >> wsel(seg_c)) == 65'd0));
endmodule

bind montmul_serial mm_check #(
    .STAGE_W(STAGE_W), .NUM_STAGES(NUM_STAGES), .LOWER_STAGES(LOWER_STAGES)
) u_mm_check (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .part_sel (part_sel),
    .m_in     (m_in),
    .result   (result),
    .ready    (ready)
);

// File: tb/sim_montmul_serial.sv
`timescale 1ns/1ps
module sim_montmul_serial;
    localparam int STAGE_W = 4;
    localparam int NSTG    = 6;
    localparam int LSTG    = 2;
    localparam int WM      = STAGE_W * NSTG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    part_sel = 2'b11;
    logic [WM-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic [WM-1:0] result;
    logic          ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    montmul_serial #(.STAGE_W(STAGE_W), .NUM_STAGES(NSTG), .LOWER_STAGES(LSTG)) u0 (
        .clk(clk), .rst(rst), .start(start), .part_sel(part_sel),
        .x_in(x_in), .y_in(y_in), .m_in(m_in), .result(result), .ready(ready)
    );

    function automatic int wsel(logic [1:0] s);
        case (s)
            2'b01:   return STAGE_W * LSTG;
            2'b10:   return WM - STAGE_W * LSTG;
            default: return WM;
        endcase
    endfunction

    function automatic longint unsigned mont_exp(longint unsigned x, longint unsigned y,
                                                 longint unsigned m, int w);
        longint unsigned half, inv;
        if (m == 1) return 0;
        half = (m + 1) / 2;
        inv  = 1;
        for (int i = 0; i < w; i++) inv = (inv * half) % m;
        return (((x * y) % m) * inv) % m;
    endfunction

    task automatic chk(input bit ok, input string what, input longint unsigned act,
                       input longint unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Runs one multiplication, checking the latency; inject puts a second
    // start pulse with other operands in the middle of the run.
    task automatic run_mul(input logic [1:0] sel, input logic [WM-1:0] x, y, m,
                           input bit inject, output logic [WM-1:0] res);
        int lat;
        lat = NSTG + 2 * (wsel(sel) - 1);
        @(negedge clk);
        part_sel = sel; x_in = x; y_in = y; m_in = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < lat; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (inject && i == 3) begin
                start = 1'b1; part_sel = 2'b11;
                x_in = WM'($urandom); y_in = WM'($urandom); m_in = WM'($urandom) | 1;
            end else begin
                start = 1'b0;
            end
        end
        chk(ready == 1'b0, "R3 ready low one edge early", ready, 0);
        @(posedge clk);
        @(negedge clk);
        chk(ready == 1'b1, "R3 ready at latency", ready, 1);
        res = result;
    endtask

    task automatic mul_check(input logic [1:0] sel, input logic [WM-1:0] x, y, m,
                             input bit inject, input string tag);
        logic [WM-1:0] r;
        longint unsigned e;
        longint unsigned msk;
        int w;
        w   = wsel(sel);
        msk = (64'd1 << w) - 1;
        run_mul(sel, x, y, m, inject, r);
        e = mont_exp(x & msk, y & msk, m & msk, w);
        chk(r == WM'(e), tag, r, e);
        chk(r < (m & msk), "R6 result below modulus", r, m & msk);
    endtask

    initial begin
        logic [WM-1:0] r1, r2, held;
        void'($urandom(32'd12345));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R8 ready low after reset", ready, 0);
        chk(result == '0, "R8 result clear after reset", result, 0);

        // Directed corners for every segment (R1, R2, R6)
        for (int s = 1; s < 4; s++) begin
            int w;
            logic [WM-1:0] mx;
            w  = wsel(2'(s));
            mx = WM'((64'd1 << w) - 1);
            mul_check(2'(s), '0, '0, mx, 0, "R1 zero operands");
            mul_check(2'(s), mx - 1, mx - 1, mx, 0, "R1 max operands");
            mul_check(2'(s), '0, '0, WM'(1), 0, "R1 modulus one");
            mul_check(2'(s), WM'(2), WM'(1), WM'(3), 0, "R2 small modulus");
        end

        // Random operands per segment (R1, R2)
        for (int s = 1; s < 4; s++) begin
            for (int t = 0; t < 12; t++) begin
                logic [WM-1:0] m, x, y, mx;
                mx = WM'((64'd1 << wsel(2'(s))) - 1);
                m  = (WM'($urandom) & mx) | 1;
                x  = WM'($urandom % m);
                y  = WM'($urandom % m);
                mul_check(2'(s), x, y, m, 0, "R1 random product");
            end
        end

        // R7: garbage above the active width in the lower and upper segments
        mul_check(2'b01, 24'hA5_5A_37, 24'hFF_00_21, 24'h3C_C0_F1, 0, "R7 lower ignores high bits");
        mul_check(2'b10, 24'hEE_12_34, 24'h77_00_99, 24'h81_FF_FB, 0, "R7 upper ignores high bits");
        chk((result >> 16) == 0, "R7 result high bits zero", result >> 16, 0);

        // R4: a start while busy changes neither result nor timing
        mul_check(2'b11, 24'h12_3456, 24'h65_4321, 24'hF0_0001, 1, "R4 busy start ignored");
        mul_check(2'b01, 24'h000_045, 24'h000_0A1, 24'h000_0C5, 1, "R4 busy start ignored low");

        // R5: hold after completion, and R2: select 00 ignored
        held = result;
        repeat (10) @(negedge clk);
        chk(ready == 1'b1, "R5 ready held", ready, 1);
        chk(result == held, "R5 result held", result, held);
        start = 1'b1; part_sel = 2'b00; x_in = 24'h1; y_in = 24'h1; m_in = 24'h7;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R2 select 00 start ignored", ready, 1);
        chk(result == held, "R2 select 00 leaves result", result, held);
        start = 1'b1; part_sel = 2'b11;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R5 accepted start clears ready", ready, 0);
        repeat (60) @(negedge clk);

        // R9: into Montgomery form and back
        for (int s = 1; s < 4; s++) begin
            longint unsigned m, g, rr;
            int w;
            w  = wsel(2'(s));
            m  = (longint'($urandom) & ((64'd1 << w) - 1)) | 1;
            if (m < 3) m = 3;
            g  = $urandom % m;
            rr = (64'd1 << (2 * w)) % m;
            run_mul(2'(s), WM'(g), WM'(rr), WM'(m), 0, r1);
            chk(r1 == WM'((g << w) % m), "R9 Montgomery form", r1, (g << w) % m);
            run_mul(2'(s), r1, WM'(1), WM'(m), 0, r2);
            chk(r2 == WM'(g), "R9 back to normal form", r2, g);
        end

        // R8: reset abandons a running multiplication
        @(negedge clk);
        part_sel = 2'b11; x_in = 24'h5; y_in = 24'h9; m_in = 24'hB; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(ready == 1'b0, "R8 reset clears ready", ready, 0);
        repeat (70) @(negedge clk);
        chk(ready == 1'b0, "R8 aborted run stays silent", ready, 0);
        mul_check(2'b10, 24'h00_1234, 24'h00_0777, 24'h00_F00D, 0, "R8 run after reset");

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule